// File: doc/BRIEF.md
# Clock Frequency-Change Sequencer

This block controls how a new clock frequency setting takes effect. Software writes a frequency control register. The register holds a PLL multiplier code, a one-bit divider code for the internal clock and a three-bit divider code for the peripheral clock. If a write leaves the multiplier code unchanged, the new divider codes take effect in the next cycle. If a write changes the multiplier code, the block enters a pause. During the pause the internal and peripheral clock enables are held low and only an 8-bit settling timer keeps running. When that timer overflows, the pending codes are applied and the clocks resume.

Software prepares the settling timer before it requests a multiplier change. It selects a prescaler and loads an initial count. The count rises by one on each prescaled tick. The pause ends when the count wraps past its highest value. The analog PLL and the clock gating cells are outside this block. The clocks are modelled as enable strobes that run on the always-present input clock.

Top module: `freq_change_seq`

## Requirements
- R1: After reset the multiplier code is 3, where code c selects a rate of 2^c, so code 3 selects a rate of 8. After reset both divider codes, the prescaler select and the count are 0, the block is not paused, and both clock enables are high in every cycle.
- R2: The register map has three registers. Address 0 is the frequency control register: bits [1:0] hold the multiplier code, bit 2 the internal divider code, bits [5:3] the peripheral divider code, and bit 7 is a read-only busy flag. Address 1 is the timer control register: bits [3:1] hold the prescaler select and bit 0 is a read-only run flag that equals busy. Address 2 holds the 8-bit count. Reads return the stored values, bits with no function read 0, and address 3 reads as 0.
- R3: A write to address 0 whose bits [1:0] differ from the active multiplier code starts a pause. Busy reads as 1 from the next cycle.
- R4: While paused, the internal clock enable and the peripheral clock enable are both 0.
- R5: The clock-out enable is 1 at all times, including during a pause.
- R6: During a pause with prescaler select k, a tick occurs every 2^(k+1) clock cycles, counted from the write that started the pause, and each tick adds 1 to the count. The pause lasts exactly 2^(k+1)*(256-C) cycles, where C is the count at the start of the pause.
- R7: When the count overflows, the multiplier and divider codes from the write that started the pause become active. In the same cycle busy and run clear, the count reads 0 and both clock enables resume.
- R8: A write to address 0 with an unchanged multiplier code updates both divider codes in the next cycle, with no pause.
- R9: While paused, writes to any register are ignored. The pending codes, the prescaler select and the running count are kept unchanged.
- R10: When not paused, the internal enable is high once every 2^d cycles, where d is the internal divider code. The peripheral enable is high once every p+1 cycles, where p is the peripheral divider code. Both enables are high in the first cycle after reset, after a divider update and after a resume.
- R11: With an initial count of 0xFF, the overflow occurs on the first prescaled tick.
- R12: During a pause, a read of address 2 returns the count as it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for the address on addr |
| intClkEn | output | 1 | Internal clock enable strobe |
| perClkEn | output | 1 | Peripheral clock enable strobe |
| clkOutEn | output | 1 | External clock output enable |
| multSel | output | 2 | Active PLL multiplier code |
| intDivSel | output | 1 | Active internal divider code |
| perDivSel | output | 3 | Active peripheral divider code |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit prescaler select and 8-bit registers. With an 8-bit count, an initial value near 0xFF reaches overflow after a few ticks. This keeps pauses that use the fastest and the slowest prescaler setting short, and covers the single-tick overflow case. The reference model is compared on every cycle. It predicts the pause length from the prescaler and the initial count, and it predicts the phase of each divider strobe from the number of cycles since the last restart.

// File: rtl/freq_seq_pkg.sv
package freq_seq_pkg;

  localparam int ADDR_FREQ  = 0;
  localparam int ADDR_TCTL  = 1;
  localparam int ADDR_COUNT = 2;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic capturePend;   // latch pending codes, clear prescaler
    logic applyDivNow;   // dividers take effect at once
    logic loadPs;        // write prescaler select
    logic loadCnt;       // write initial count
    logic cntStep;       // advance the settling count
    logic applyPend;     // overflow: pending codes become active
    logic divRestart;    // restart divider phase
    logic gateClocks;    // pause in progress
  } seqStrobe_t;

  typedef struct packed {
    logic multDiffers;
    logic tick;
    logic cntAtMax;
  } seqStatus_t;

endpackage

// File: rtl/freq_seq_div.sv
module freq_seq_div #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic         restart,
  input  logic [W-1:0] lastIdx,
  output logic         strobe
);
  logic [W-1:0] phase;

  assign strobe = !hold && (phase == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   phase <= '0;
    else if (hold || restart)    phase <= '0;
    else if (phase == lastIdx)   phase <= '0;
    else                         phase <= phase + 1'b1;
  end
endmodule

// File: rtl/freq_seq_ctrl.sv
module freq_seq_ctrl
  import freq_seq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  seqStatus_t        stat,
  output seqStrobe_t        strb
);
  logic busy;
  logic wrIdle;
  logic frqWr;
  logic overflow;

  assign wrIdle   = wrEn && !busy;
  assign frqWr    = wrIdle && (addr == ADDR_W'(ADDR_FREQ));
  assign overflow = busy && stat.tick && stat.cntAtMax;

  always_comb begin
    strb             = '0;
    strb.capturePend = frqWr && stat.multDiffers;
    strb.applyDivNow = frqWr && !stat.multDiffers;
    strb.loadPs      = wrIdle && (addr == ADDR_W'(ADDR_TCTL));
    strb.loadCnt     = wrIdle && (addr == ADDR_W'(ADDR_COUNT));
    strb.cntStep     = busy && stat.tick;
    strb.applyPend   = overflow;
    strb.divRestart  = strb.applyDivNow || overflow;
    strb.gateClocks  = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               busy <= 1'b0;
    else if (frqWr && stat.multDiffers)      busy <= 1'b1;
    else if (overflow)                       busy <= 1'b0;
  end
endmodule

// File: rtl/freq_seq_dp.sv
module freq_seq_dp
  import freq_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PS_W     = 3,
  parameter int MULT_W   = 2,
  parameter int PER_W    = 3,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int MULT_RST = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  output logic [DATA_W-1:0] rdData,
  output logic [MULT_W-1:0] multSel,
  output logic              intDivSel,
  output logic [PER_W-1:0]  perDivSel,
  output logic              intClkEn,
  output logic              perClkEn
);
  localparam int INT_POS = MULT_W;
  localparam int PER_LSB = MULT_W + 1;
  localparam int PSC_W   = 1 << PS_W;
  localparam int N_DIV   = 2;

  logic [MULT_W-1:0] pendMult;
  logic              pendInt;
  logic [PER_W-1:0]  pendPer;
  logic [PS_W-1:0]   psSel;
  logic [PSC_W-1:0]  psCnt;
  logic [PSC_W-1:0]  psLimit;
  logic [PSC_W:0]    psLimitW;
  logic [CNT_W-1:0]  cnt;

  // Prescaler: tick every 2^(k+1) cycles
  assign psLimitW = ({{PSC_W{1'b0}}, 1'b1} << ({1'b0, psSel} + 1'b1))
                    - {{PSC_W{1'b0}}, 1'b1};
  assign psLimit  = psLimitW[PSC_W-1:0];

  assign stat.tick        = (psCnt == psLimit);
  assign stat.cntAtMax    = &cnt;
  assign stat.multDiffers = (wrData[MULT_W-1:0] != multSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 psCnt <= '0;
    else if (strb.capturePend) psCnt <= '0;
    else if (strb.gateClocks)  psCnt <= stat.tick ? '0 : psCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.loadCnt) cnt <= wrData[CNT_W-1:0];
    else if (strb.cntStep) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            psSel <= '0;
    else if (strb.loadPs) psSel <= wrData[PS_W:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMult <= MULT_W'(MULT_RST);
      pendInt  <= 1'b0;
      pendPer  <= '0;
    end else if (strb.capturePend) begin
      pendMult <= wrData[MULT_W-1:0];
      pendInt  <= wrData[INT_POS];
      pendPer  <= wrData[PER_LSB +: PER_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      multSel   <= MULT_W'(MULT_RST);
      intDivSel <= 1'b0;
      perDivSel <= '0;
    end else if (strb.applyPend) begin
      multSel   <= pendMult;
      intDivSel <= pendInt;
      perDivSel <= pendPer;
    end else if (strb.applyDivNow) begin
      intDivSel <= wrData[INT_POS];
      perDivSel <= wrData[PER_LSB +: PER_W];
    end
  end

  // Clock enable strobes, one divider per domain
  logic [N_DIV-1:0][PER_W-1:0] divLast;
  logic [N_DIV-1:0]            divStb;

  assign divLast[0] = PER_W'(intDivSel);
  assign divLast[1] = perDivSel;

  for (genvar gi = 0; gi < N_DIV; gi++) begin : g_div
    freq_seq_div #(.W(PER_W)) uDiv (
      .clk     (clk),
      .rstN    (rstN),
      .hold    (strb.gateClocks),
      .restart (strb.divRestart),
      .lastIdx (divLast[gi]),
      .strobe  (divStb[gi])
    );
  end

  assign intClkEn = divStb[0];
  assign perClkEn = divStb[1];

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(ADDR_FREQ): begin
        rdData[MULT_W-1:0]         = multSel;
        rdData[INT_POS]            = intDivSel;
        rdData[PER_LSB +: PER_W]   = perDivSel;
        rdData[DATA_W-1]           = strb.gateClocks;
      end
      ADDR_W'(ADDR_TCTL): begin
        rdData[0]      = strb.gateClocks;
        rdData[PS_W:1] = psSel;
      end
      ADDR_W'(ADDR_COUNT): rdData[CNT_W-1:0] = cnt;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
  import freq_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PS_W     = 3,
  parameter int MULT_W   = 2,
  parameter int PER_W    = 3,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int MULT_RST = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              intClkEn,
  output logic              perClkEn,
  output logic              clkOutEn,
  output logic [MULT_W-1:0] multSel,
  output logic              intDivSel,
  output logic [PER_W-1:0]  perDivSel
);
  seqStrobe_t seqStrb;
  seqStatus_t seqStat;

  assign clkOutEn = 1'b1;

  freq_seq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .addr (addr),
    .stat (seqStat),
    .strb (seqStrb)
  );

  freq_seq_dp #(
    .CNT_W(CNT_W), .PS_W(PS_W), .MULT_W(MULT_W), .PER_W(PER_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MULT_RST(MULT_RST)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .addr      (addr),
    .strb      (seqStrb),
    .stat      (seqStat),
    .rdData    (rdData),
    .multSel   (multSel),
    .intDivSel (intDivSel),
    .perDivSel (perDivSel),
    .intClkEn  (intClkEn),
    .perClkEn  (perClkEn)
  );
endmodule

// File: rtl/freq_change_chk.sv
module freq_change_chk #(
  parameter int MULT_W = 2,
  parameter int PER_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              paused,
  input logic              intClkEn,
  input logic              perClkEn,
  input logic [MULT_W-1:0] multSel,
  input logic              intDivSel,
  input logic [PER_W-1:0]  perDivSel
);
  // R3
  pause_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !paused && addr == '0 && wrData[MULT_W-1:0] != multSel) |=> paused);

  // R4
  gated_clocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> (!intClkEn && !perClkEn));

  // R9
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paused && $past(paused)) |-> ($stable(multSel) && $stable(intDivSel) && $stable(perDivSel)));

  // R7
  resume_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(paused) |-> (intClkEn && perClkEn && !$stable(multSel)));

  // R8
  div_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !paused && addr == '0 && wrData[MULT_W-1:0] == multSel)
    |=> (!paused && intDivSel == $past(wrData[MULT_W])
         && perDivSel == $past(wrData[MULT_W+1 +: PER_W])));
endmodule

bind freq_change_seq freq_change_chk #(
  .MULT_W(MULT_W), .PER_W(PER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .paused    (seqStrb.gateClocks),
  .intClkEn  (intClkEn),
  .perClkEn  (perClkEn),
  .multSel   (multSel),
  .intDivSel (intDivSel),
  .perDivSel (perDivSel)
);

// File: tb/test_freq_change_seq.sv
module test_freq_change_seq;
  localparam int CLK_P     = 10;
  localparam int WDOG_CYC  = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       intClkEn, perClkEn, clkOutEn, intDivSel;
  logic [1:0] multSel;
  logic [2:0] perDivSel;

  freq_change_seq i_freq_change_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .intClkEn(intClkEn), .perClkEn(perClkEn),
    .clkOutEn(clkOutEn), .multSel(multSel), .intDivSel(intDivSel),
    .perDivSel(perDivSel)
  );

  always #(CLK_P/2) clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  string curReq = "R1";

  // Behavioural reference model
  int mMult, mInt, mPer, mPs, mCnt, mBusy;
  int pMult, pInt, pPer;
  int pauseLeft, pauseTotal, pauseBase, ph;

  always @(posedge clk) begin
    if (!rstN) begin
      mMult = 3; mInt = 0; mPer = 0; mPs = 0; mCnt = 0; mBusy = 0;
      pMult = 3; pInt = 0; pPer = 0; pauseLeft = 0; pauseTotal = 0;
      pauseBase = 0; ph = 0;
    end else if (mBusy != 0) begin
      pauseLeft = pauseLeft - 1;
      ph = 0;
      if (pauseLeft == 0) begin
        mBusy = 0; mMult = pMult; mInt = pInt; mPer = pPer; mCnt = 0;
      end
    end else begin
      ph = ph + 1;
      if (wrEn) begin
        case (addr)
          2'd0: begin
            if (int'(wrData[1:0]) != mMult) begin
              mBusy = 1;
              pMult = int'(wrData[1:0]); pInt = int'(wrData[2]);
              pPer = int'(wrData[5:3]);
              pauseBase = mCnt;
              pauseTotal = (2 << mPs) * (256 - mCnt);
              pauseLeft = pauseTotal;
            end else begin
              mInt = int'(wrData[2]); mPer = int'(wrData[5:3]);
            end
            ph = 0;
          end
          2'd1: mPs = int'(wrData[3:1]);
          2'd2: mCnt = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  function automatic int expCount();
    if (mBusy != 0) return (pauseBase + (pauseTotal - pauseLeft) / (2 << mPs)) & 255;
    return mCnt;
  endfunction

  function automatic int expRead();
    case (addr)
      2'd0: return (mBusy << 7) | (mPer << 3) | (mInt << 2) | mMult;
      2'd1: return (mPs << 1) | mBusy;
      2'd2: return expCount();
      default: return 0;
    endcase
  endfunction

  // Compare every cycle, a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rstN) begin
      check(mBusy != 0 ? "R4" : "R10", "intClkEn", int'(intClkEn),
            (mBusy == 0 && (ph % (1 << mInt)) == 0) ? 1 : 0);
      check(mBusy != 0 ? "R4" : "R10", "perClkEn", int'(perClkEn),
            (mBusy == 0 && (ph % (mPer + 1)) == 0) ? 1 : 0);
      check("R5", "clkOutEn", int'(clkOutEn), 1);
      check(curReq, "multSel", int'(multSel), mMult);
      check(curReq, "intDivSel", int'(intDivSel), mInt);
      check(curReq, "perDivSel", int'(perDivSel), mPer);
      check((addr == 2'd2 && mBusy != 0) ? "R12" : "R2", "rdData", int'(rdData), expRead());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WDOG_CYC) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    addr = a;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    idle(4);
    curReq = "R2";
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      idle(2);
    end
    // R8: same multiplier, new dividers
    curReq = "R8";
    wr(2'd0, 8'h17);
    idle(20);
    wr(2'd0, 8'h3B);
    idle(20);
    // R11: single-tick overflow, R3 pause entry
    curReq = "R11";
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    curReq = "R3";
    wr(2'd0, 8'h1D);
    rd(2'd0);
    idle(10);
    // R6: prescaler 2, sixteen ticks; R9 writes while paused
    curReq = "R6";
    wr(2'd1, 8'h04);
    wr(2'd2, 8'hF0);
    wr(2'd0, 8'h02);
    curReq = "R9";
    rd(2'd2);
    idle(20);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h0E);
    wr(2'd2, 8'h00);
    rd(2'd1);
    idle(200);
    // R12: slowest prescaler, count watched while it rises
    curReq = "R12";
    wr(2'd1, 8'h0E);
    wr(2'd2, 8'hFE);
    wr(2'd0, 8'h27);
    rd(2'd2);
    idle(600);
    curReq = "R7";
    rd(2'd0);
    idle(10);
    rd(2'd1);
    idle(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule